// File: doc/BRIEF.md
# Two-Phase Addressed Single-Bit Memory

This block is a bit-wide storage array whose address reaches it in two halves over one shared address port. A row number is placed on the port and captured while an active-low row strobe is held low. The column number then goes on the same pins and is captured with an active-low column strobe. Each completed access reads or writes exactly one bit. Because the address comes in two halves, every access takes at least two clock cycles.

The array also keeps track of how long each row has gone without being opened. Opening a row counts as a refresh of that row. This holds whether the row is opened on its own or as the first half of an access. A per-row cycle counter raises a sticky flag if any row goes a parameterized number of cycles without a refresh. A column strobe that arrives while no row is open is rejected, and it raises a sticky protocol-error flag. Charge leakage is not modelled: stored bits persist even when the refresh deadline is missed.

Top module: `mux_addr_bitmem`

## Requirements
- R1: On the first rising clock edge at which `row_stb_n` is low while no row is open, the row index `addr[ROW_W-1:0]` is captured and the row stays open until a clock edge sees `row_stb_n` high.
- R2: On the first rising edge at which `col_stb_n` is low while a row is open, the column index `addr[COL_W-1:0]` is captured. If `wr_n` is low, `din` is written to that single bit of the open row and no other bit changes.
- R3: If `wr_n` is high at that edge, `dout` takes the stored bit of the addressed cell in the same edge. It then holds that value for as long as `col_stb_n` stays low.
- R4: `dout` is 0 after any clock edge at which `col_stb_n` is high, and after a write access.
- R5: A column strobe sampled low while no row is open performs no read or write and leaves `dout` at 0. It sets `proto_err`, which stays 1 until reset.
- R6: Every row opening resets the refresh timer of that row, with or without a following column access.
- R7: A row's timer counts clock edges since that row was last refreshed. One edge after any timer reaches `REFRESH_LIMIT`, `refresh_miss` goes to 1 and stays 1 until reset.
- R8: While `rst_n` is low, `dout`, `proto_err` and `refresh_miss` are 0, every stored bit is cleared, no row is open and all refresh timers restart from 0.
- R9: The column strobe must fall at least one clock edge after the row has been captured. If both strobes are first sampled low at the same edge, that column strobe is treated as having no open row (R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | max(ROW_W,COL_W) | Shared address port: row index, then column index |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_n | input | 1 | Active-low write enable, sampled with the column strobe |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 while the column strobe is high |
| proto_err | output | 1 | Sticky flag: column strobe seen with no open row |
| refresh_miss | output | 1 | Sticky flag: a row exceeded its refresh interval |

## Verification
Some properties are checked on every cycle. Both flags must be sticky. `proto_err` may only rise after a low column strobe. `dout` must be 0 after a high column strobe and must hold steady while the column strobe stays low.

Other behaviours can only be shown by the bench's scenarios, because they depend on the stored contents and on exact timing:
- that the correct bit comes back after random mixes of reads and writes;
- that a rejected column write leaves the cell untouched;
- that the refresh flag rises exactly one edge after a row's deadline and not before.

// File: rtl/mab_pkg.sv
package mab_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   function automatic int unsigned wider(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mab_strobe_ctl.sv
module mab_strobe_ctl
   import mab_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             row_stb_n,
   input  logic             col_stb_n,
   input  logic             wr_n,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_idx,
   output acc_e             acc,
   output logic             act_fire,
   output logic [ROW_W-1:0] act_row,
   output logic             proto_err
);

   logic row_open;
   logic col_busy;
   logic col_fire;
   logic col_orphan;

   assign act_fire   = !row_stb_n && !row_open;
   assign act_row    = addr[ROW_W-1:0];
   assign col_fire   = !col_stb_n && !col_busy && row_open;
   assign col_orphan = !col_stb_n && !col_busy && !row_open;
   assign col_idx    = addr[COL_W-1:0];

   always_comb begin
      acc = ACC_IDLE;
      if (col_fire) acc = wr_n ? ACC_READ : ACC_WRITE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open  <= 1'b0;
         row_q     <= '0;
         col_busy  <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         if (row_stb_n) begin
            row_open <= 1'b0;
         end else if (!row_open) begin
            row_open <= 1'b1;
            row_q    <= act_row;
         end
         if (col_stb_n)     col_busy  <= 1'b0;
         else if (col_fire) col_busy  <= 1'b1;
         if (col_orphan)    proto_err <= 1'b1;
      end
   end

endmodule

// File: rtl/mab_cell_array.sv
module mab_cell_array
   import mab_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] row_q,
   input  logic [COL_W-1:0] col_idx,
   input  acc_e             acc,
   input  logic             col_stb_n,
   input  logic             din,
   output logic             dout
);

   localparam int ROWS = 1 << ROW_W;
   localparam int COLS = 1 << COL_W;

   logic [COLS-1:0] cells [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      end else if (acc == ACC_WRITE) begin
         cells[row_q][col_idx] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= 1'b0;
      end else if (col_stb_n) begin
         dout <= 1'b0;
      end else if (acc == ACC_READ) begin
         dout <= cells[row_q][col_idx];
      end else if (acc == ACC_WRITE) begin
         dout <= 1'b0;
      end
   end

endmodule

// File: rtl/mab_refresh_mon.sv
module mab_refresh_mon #(
   parameter int ROW_W         = 3,
   parameter int REFRESH_LIMIT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic [ROW_W-1:0] act_row,
   output logic             refresh_miss
);

   localparam int ROWS = 1 << ROW_W;
   localparam int CW   = $clog2(REFRESH_LIMIT + 1);

   logic [ROWS-1:0] expired;

   for (genvar r = 0; r < ROWS; r++) begin : g_row_timer
      logic [CW-1:0] age;
      logic          hit;
      assign hit        = act_fire && (act_row == ROW_W'(r));
      assign expired[r] = (age == CW'(REFRESH_LIMIT));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           age <= '0;
         else if (hit)         age <= '0;
         else if (!expired[r]) age <= age + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        refresh_miss <= 1'b0;
      else if (|expired) refresh_miss <= 1'b1;
   end

endmodule

// File: rtl/mux_addr_bitmem.sv
module mux_addr_bitmem
   import mab_pkg::*;
#(
   parameter int ROW_W         = 3,
   parameter int COL_W         = 3,
   parameter int REFRESH_LIMIT = 100,
   localparam int AW           = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          row_stb_n,
   input  logic          col_stb_n,
   input  logic          wr_n,
   input  logic          din,
   output logic          dout,
   output logic          proto_err,
   output logic          refresh_miss
);

   if (ROW_W < 1 || ROW_W > 12) begin : g_bad_row
      $error("mux_addr_bitmem: ROW_W out of range");
   end
   if (COL_W < 1 || COL_W > 12) begin : g_bad_col
      $error("mux_addr_bitmem: COL_W out of range");
   end
   if (REFRESH_LIMIT < 2) begin : g_bad_limit
      $error("mux_addr_bitmem: REFRESH_LIMIT must be at least 2");
   end
   if (AW != int'(wider(ROW_W, COL_W))) begin : g_bad_aw
      $error("mux_addr_bitmem: address width mismatch");
   end

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_idx;
   acc_e             acc;
   logic             act_fire;
   logic [ROW_W-1:0] act_row;

   mab_strobe_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .row_stb_n (row_stb_n),
      .col_stb_n (col_stb_n),
      .wr_n      (wr_n),
      .row_q     (row_q),
      .col_idx   (col_idx),
      .acc       (acc),
      .act_fire  (act_fire),
      .act_row   (act_row),
      .proto_err (proto_err)
   );

   mab_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_q     (row_q),
      .col_idx   (col_idx),
      .acc       (acc),
      .col_stb_n (col_stb_n),
      .din       (din),
      .dout      (dout)
   );

   mab_refresh_mon #(.ROW_W(ROW_W), .REFRESH_LIMIT(REFRESH_LIMIT)) u_refresh (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_fire     (act_fire),
      .act_row      (act_row),
      .refresh_miss (refresh_miss)
   );

endmodule

// File: rtl/mab_checker.sv
module mab_checker (
   input logic clk,
   input logic rst_n,
   input logic col_stb_n,
   input logic dout,
   input logic proto_err,
   input logic refresh_miss
);

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R4
   dout_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm != 2'd0) && $past(col_stb_n) |-> !dout);

   // R3
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) && $past(!col_stb_n) && $past(!col_stb_n, 2) |-> $stable(dout));

   // R5
   proto_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R5
   proto_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm != 2'd0) && $rose(proto_err) |-> $past(!col_stb_n));

   // R7
   refresh_miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_miss |=> refresh_miss);

endmodule

bind mux_addr_bitmem mab_checker u_chk (.*);

// File: tb/tb_mux_addr_bitmem.sv
module tb_mux_addr_bitmem;

   localparam int ROW_W = 3;
   localparam int COL_W = 3;
   localparam int LIMIT = 100;
   localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int ROWS  = 1 << ROW_W;
   localparam int COLS  = 1 << COL_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          row_stb_n = 1'b1;
   logic          col_stb_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          din = 1'b0;
   logic          dout;
   logic          proto_err;
   logic          refresh_miss;

   bit model [ROWS][COLS];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mux_addr_bitmem #(.ROW_W(ROW_W), .COL_W(COL_W), .REFRESH_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb_n(row_stb_n),
      .col_stb_n(col_stb_n), .wr_n(wr_n), .din(din), .dout(dout),
      .proto_err(proto_err), .refresh_miss(refresh_miss)
   );

   function automatic bit expect_read(input int r, input int c);
      return model[r][c];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic access(input int r, input int c, input bit wr, input bit d, input bit hold);
      bit e;
      @(negedge clk);
      addr = AW'(r); row_stb_n = 1'b0;
      @(negedge clk);
      addr = AW'(c); col_stb_n = 1'b0; wr_n = !wr; din = d;
      @(negedge clk);
      if (wr) begin
         model[r][c] = d;
         check(dout == 1'b0, "R4 dout after write", int'(dout), 0);
      end else begin
         e = expect_read(r, c);
         check(dout == e, "R3/R2 read data", int'(dout), int'(e));
         if (hold) begin
            @(negedge clk);
            check(dout == e, "R3 read hold", int'(dout), int'(e));
         end
      end
      col_stb_n = 1'b1; row_stb_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      check(dout == 1'b0, "R4 dout after column release", int'(dout), 0);
   endtask

   task automatic sweep();
      for (int r = 0; r < ROWS; r++) begin
         @(negedge clk);
         addr = AW'(r); row_stb_n = 1'b0;
         @(negedge clk);
         row_stb_n = 1'b1;
      end
   endtask

   initial begin
      void'($urandom(32'h1b2c3d4e));
      repeat (3) @(negedge clk);
      check(dout == 1'b0 && proto_err == 1'b0 && refresh_miss == 1'b0,
            "R8 outputs in reset", int'({dout, proto_err, refresh_miss}), 0);
      rst_n = 1'b1;
      // R8: cells read back as zero after reset; R9 index slicing
      access(0, 0, 1'b0, 1'b0, 1'b0);
      access(ROWS-1, COLS-1, 1'b0, 1'b0, 1'b1);
      // R2: directed write isolation, neighbouring bits stay 0
      access(2, 3, 1'b1, 1'b1, 1'b0);
      access(2, 4, 1'b0, 1'b0, 1'b0);
      access(3, 3, 1'b0, 1'b0, 1'b0);
      access(2, 3, 1'b0, 1'b0, 1'b1);
      // R1/R6: random traffic with periodic refresh sweeps
      for (int blk = 0; blk < 40; blk++) begin
         for (int k = 0; k < 8; k++) begin
            access(int'($urandom_range(0, ROWS-1)), int'($urandom_range(0, COLS-1)),
                   bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                   bit'($urandom_range(0, 1)));
         end
         sweep();
      end
      check(proto_err == 1'b0, "R5 no error on legal traffic", int'(proto_err), 0);
      check(refresh_miss == 1'b0, "R6 no miss with regular refresh", int'(refresh_miss), 0);
      // R5 / R9: column strobe with no open row is ignored
      access(3, 5, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      addr = AW'(5); col_stb_n = 1'b0; wr_n = 1'b0; din = 1'b1;
      @(negedge clk);
      check(proto_err == 1'b1, "R5 error flag set", int'(proto_err), 1);
      check(dout == 1'b0, "R5 dout stays low", int'(dout), 0);
      col_stb_n = 1'b1; wr_n = 1'b1;
      // R9: both strobes at the same edge count as orphaned column
      @(negedge clk);
      addr = AW'(3); row_stb_n = 1'b0; col_stb_n = 1'b0; wr_n = 1'b0; din = 1'b1;
      @(negedge clk);
      row_stb_n = 1'b1; col_stb_n = 1'b1; wr_n = 1'b1;
      access(3, 5, 1'b0, 1'b0, 1'b0);
      access(3, 3, 1'b0, 1'b0, 1'b0);
      check(proto_err == 1'b1, "R5 error flag sticky", int'(proto_err), 1);
      // R7: exact deadline after a sweep (row 0 refreshed first)
      sweep();
      repeat (LIMIT - 2*ROWS + 2) @(negedge clk);
      check(refresh_miss == 1'b0, "R7 no miss at deadline edge", int'(refresh_miss), 0);
      @(negedge clk);
      check(refresh_miss == 1'b1, "R7 miss one edge after deadline", int'(refresh_miss), 1);
      sweep();
      check(refresh_miss == 1'b1, "R7 miss sticky", int'(refresh_miss), 1);
      // R8: reset clears flags and cells
      rst_n = 1'b0;
      @(negedge clk);
      check(proto_err == 1'b0 && refresh_miss == 1'b0, "R8 flags cleared",
            int'({proto_err, refresh_miss}), 0);
      rst_n = 1'b1;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) model[r][c] = 1'b0;
      access(2, 3, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule